// File: doc/BRIEF.md
# Multi-Mode Configurable Peripheral Port

This block is an eight-pin general-purpose port of the kind found inside a programmable peripheral that sits beside a microcontroller. Each pin is given one of three jobs by a static two-bit mode field. It can be a host-controlled I/O pin whose output enable comes from a direction register. It can drive one bit of a latched address outward. It can drive an active-low chip select built as a sum of product terms. The host reaches two registers through a plain write strobe and a one-bit register select. Reading back returns either the live pin levels or the direction register.

The multiplexed address enters on `addr_in` and is captured while `addr_strobe` is high. It holds once the strobe falls. Chip-select product terms look at the latched address together with a few live control inputs. Each term is a configurable AND of true and complemented literals. The lower half of the port carries four terms per pin and the upper half carries two. All product-term programming arrives on static configuration inputs. Pad drivers stay outside; the port only presents an output value and an output enable per pin, and receives the resolved pad level back on `pin_in`.

Top module: `mport_port`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, the data and direction registers are zero, so every pin in I/O mode has its output enable low and the direction read-back is 0x00.
- R2: On a rising clock edge with `host_we` high, `host_wdata` is stored in the data register when `host_sel` is 0 and in the direction register when `host_sel` is 1. The new value is visible right after that edge.
- R3: A pin in I/O mode (mode 00) has `pin_oe` equal to its direction bit (1 = output, 0 = input) and `pin_out` equal to its data register bit, whatever its direction.
- R4: `host_rdata` is combinational. With `host_sel` = 0 it returns `pin_in`, the live pad level. With `host_sel` = 1 it returns the direction register.
- R5: The address latch loads `addr_in` on every rising edge where `addr_strobe` is high and holds while it is low. A pin in address mode (mode 01) has `pin_oe` = 1 and `pin_out` equal to its latched address bit.
- R6: A pin in chip-select mode (mode 10) has `pin_oe` = 1 and `pin_out` low exactly when at least one of its enabled product terms is true. The term inputs are a 12-bit vector: bits 0–7 are the latched address and bits 8–11 are `ctrl_in`. A term with `pt_en` low is never true. An enabled term is true when every input bit i with `pt_use[k*12+i]` = 1 equals `pt_pol[k*12+i]`, where polarity 1 selects the true literal and 0 selects the complement.
- R7: Pins 0–3 own four terms each and pins 4–7 own two each. Term t of pin p has flat index k = 4p+t for p < 4 and k = 16+2(p-4)+t for p ≥ 4, so 24 terms in total.
- R8: Pin p's mode is `pin_mode[2p+1:2p]`. Code 11 behaves exactly like I/O mode.
- R9: Changing pin modes never alters the data or direction registers. Values written while a pin is in another mode appear once it returns to I/O mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 data/pins, 1 direction |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| addr_strobe | input | 1 | Address latch enable, active high |
| addr_in | input | 8 | Multiplexed address input |
| ctrl_in | input | 4 | Live control inputs to the product terms |
| pin_mode | input | 16 | Two-bit mode per pin |
| pt_en | input | 24 | Enable per product term |
| pt_use | input | 288 | Literal select, 12 bits per term |
| pt_pol | input | 288 | Literal polarity, 12 bits per term |
| pin_in | input | 8 | Resolved pad levels |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
Directed patterns come first. Alternating direction and data bytes such as 0xA5 and 0x3C separate the output enable from the output value in I/O mode. A latch then a changed address with the strobe low separates capture from transparency. Single-literal chip selects on pin 0 and pin 4 separate true from complemented literals and address inputs from control inputs. A chip-select pin with all terms disabled must stay high. Random sweeps then mix all four mode codes per pin, sparse literal masks, random enables, writes and strobes, and random external pad levels. These sweeps exercise the per-half term counts and the flat term indexing; a misplaced term offset or a wrong literal polarity shows up as a chip select that differs from the model.

// File: rtl/mport_pkg.sv
package mport_pkg;
  typedef enum logic [1:0] {
    PM_IO   = 2'b00,
    PM_ADDR = 2'b01,
    PM_CS   = 2'b10,
    PM_RSVD = 2'b11
  } pin_mode_e;

  // first flat term index owned by pin p
  function automatic int term_base(int p, int half, int lo, int hi);
    return (p < half) ? p * lo : half * lo + (p - half) * hi;
  endfunction

  function automatic int term_count(int p, int half, int lo, int hi);
    return (p < half) ? lo : hi;
  endfunction
endpackage

// File: rtl/mport_regs.sv
module mport_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we) begin
      if (sel) dir_q  <= wdata;
      else     data_q <= wdata;
    end
  end

  assign rdata = sel ? dir_q : pin_in;
endmodule

// File: rtl/mport_alatch.sv
module mport_alatch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] lat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (load) lat_q <= addr_in;
  end
endmodule

// File: rtl/mport_sop.sv
module mport_sop
  import mport_pkg::*;
#(
  parameter int W     = 8,
  parameter int NI    = 12,
  parameter int PT_LO = 4,
  parameter int PT_HI = 2,
  parameter int TOT   = 24
) (
  input  logic [NI-1:0]     sop_in,
  input  logic [TOT-1:0]    pt_en,
  input  logic [TOT*NI-1:0] pt_use,
  input  logic [TOT*NI-1:0] pt_pol,
  output logic [W-1:0]      cs_n
);
  localparam int HALF = W / 2;

  for (genvar p = 0; p < W; p++) begin : g_pin
    localparam int BASE = term_base(p, HALF, PT_LO, PT_HI);
    localparam int CNT  = term_count(p, HALF, PT_LO, PT_HI);
    logic [CNT-1:0] hit;
    for (genvar t = 0; t < CNT; t++) begin : g_term
      localparam int K = BASE + t;
      // literal passes when unused or when input matches polarity
      assign hit[t] = pt_en[K] &
        (&(~pt_use[K*NI +: NI] | ~(sop_in ^ pt_pol[K*NI +: NI])));
    end
    assign cs_n[p] = ~(|hit);
  end
endmodule

// File: rtl/mport_mux.sv
module mport_mux
  import mport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2*W-1:0] mode,
  input  logic [W-1:0]   data_q,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   lat_q,
  input  logic [W-1:0]   cs_n,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);
  always_comb begin
    for (int p = 0; p < W; p++) begin
      case (pin_mode_e'(mode[2*p +: 2]))
        PM_ADDR: begin pin_oe[p] = 1'b1;     pin_out[p] = lat_q[p];  end
        PM_CS:   begin pin_oe[p] = 1'b1;     pin_out[p] = cs_n[p];   end
        default: begin pin_oe[p] = dir_q[p]; pin_out[p] = data_q[p]; end
      endcase
    end
  end
endmodule

// File: rtl/mport_port.sv
module mport_port #(
  parameter int W     = 8,
  parameter int NCTRL = 4,
  parameter int PT_LO = 4,
  parameter int PT_HI = 2,
  localparam int HALF = W / 2,
  localparam int NI   = W + NCTRL,
  localparam int TOT  = HALF * (PT_LO + PT_HI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [W-1:0]      host_wdata,
  output logic [W-1:0]      host_rdata,
  input  logic              addr_strobe,
  input  logic [W-1:0]      addr_in,
  input  logic [NCTRL-1:0]  ctrl_in,
  input  logic [2*W-1:0]    pin_mode,
  input  logic [TOT-1:0]    pt_en,
  input  logic [TOT*NI-1:0] pt_use,
  input  logic [TOT*NI-1:0] pt_pol,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);
  logic [W-1:0] data_q, dir_q, lat_q, cs_n;

  mport_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel),
    .wdata(host_wdata), .pin_in(pin_in),
    .data_q(data_q), .dir_q(dir_q), .rdata(host_rdata)
  );

  mport_alatch #(.W(W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(addr_strobe),
    .addr_in(addr_in), .lat_q(lat_q)
  );

  mport_sop #(.W(W), .NI(NI), .PT_LO(PT_LO), .PT_HI(PT_HI), .TOT(TOT)) u_sop (
    .sop_in({ctrl_in, lat_q}), .pt_en(pt_en),
    .pt_use(pt_use), .pt_pol(pt_pol), .cs_n(cs_n)
  );

  mport_mux #(.W(W)) u_mux (
    .mode(pin_mode), .data_q(data_q), .dir_q(dir_q),
    .lat_q(lat_q), .cs_n(cs_n), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/mport_port_chk.sv
module mport_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_we,
  input logic         host_sel,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] host_rdata,
  input logic         addr_strobe,
  input logic [W-1:0] addr_in,
  input logic [2*W-1:0] pin_mode,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0)); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel) |=> (dir_q == $past(host_wdata))); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_sel) |=> $stable(dir_q)); // R9
  AST_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> (host_rdata == dir_q)); // R4
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> (lat_q == $past(addr_in))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |=> $stable(lat_q)); // R5

  for (genvar p = 0; p < W; p++) begin : g_pin
    AST_IO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode[2*p+1] == pin_mode[2*p]) |-> (pin_oe[p] == dir_q[p])); // R8
    AST_DRIVE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode[2*p+1] != pin_mode[2*p]) |-> pin_oe[p]); // R6
    AST_ADDR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode[2*p +: 2] == 2'b01) |-> (pin_out[p] == lat_q[p])); // R5
  end
endmodule

bind mport_port mport_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .host_rdata(host_rdata),
  .addr_strobe(addr_strobe), .addr_in(addr_in), .pin_mode(pin_mode),
  .dir_q(dir_q), .lat_q(lat_q), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_mport_port.sv
`timescale 1ns/1ps
module tb_mport_port;
  localparam int W = 8, NC = 4, NI = 12, TOT = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic host_we, host_sel, addr_strobe;
  logic [W-1:0] host_wdata, host_rdata, addr_in, ext, pin_in, pin_out, pin_oe;
  logic [NC-1:0] ctrl_in;
  logic [2*W-1:0] pin_mode;
  logic [TOT-1:0] pt_en;
  logic [TOT*NI-1:0] pt_use, pt_pol;

  logic [W-1:0] m_data, m_dir, m_lat;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  mport_port dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .addr_strobe(addr_strobe), .addr_in(addr_in), .ctrl_in(ctrl_in),
    .pin_mode(pin_mode), .pt_en(pt_en), .pt_use(pt_use), .pt_pol(pt_pol),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int tbase(int p);
    return (p < 4) ? 4 * p : 16 + 2 * (p - 4);
  endfunction

  function automatic logic term_true(int k);
    logic [NI-1:0] v;
    v = {ctrl_in, m_lat};
    if (!pt_en[k]) return 1'b0;
    for (int i = 0; i < NI; i++)
      if (pt_use[k*NI+i] && (v[i] != pt_pol[k*NI+i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_oe(int p);
    case (pin_mode[2*p +: 2])
      2'b01, 2'b10: return 1'b1;
      default:      return m_dir[p];
    endcase
  endfunction

  function automatic logic exp_out(int p);
    logic any;
    any = 1'b0;
    case (pin_mode[2*p +: 2])
      2'b01: return m_lat[p];
      2'b10: begin
        for (int t = 0; t < ((p < 4) ? 4 : 2); t++) any |= term_true(tbase(p) + t);
        return ~any;
      end
      default: return m_data[p];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows the inputs that are present at the rising edge
  task automatic tick();
    @(posedge clk);
    if (host_we) begin
      if (host_sel) m_dir = host_wdata;
      else          m_data = host_wdata;
    end
    if (addr_strobe) m_lat = addr_in;
    @(negedge clk);
    host_we = 1'b0;
    addr_strobe = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] v);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    tick();
  endtask

  task automatic latch(input logic [W-1:0] a);
    addr_strobe = 1'b1; addr_in = a;
    tick();
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] eo, ev, pad;
    #1;
    for (int p = 0; p < W; p++) begin
      eo[p] = exp_oe(p);
      ev[p] = exp_out(p);
    end
    chk({tag, " oe"}, pin_oe, eo);
    chk({tag, " out"}, pin_out, ev);
    pad = (eo & ev) | (~eo & ext);
    host_sel = 1'b0; #1;
    chk("R4 pin readback", host_rdata, pad);
    host_sel = 1'b1; #1;
    chk("R4 dir readback", host_rdata, m_dir);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; host_we = 1'b0; host_sel = 1'b0; host_wdata = '0;
    addr_strobe = 1'b0; addr_in = '0; ctrl_in = '0; ext = 8'h96;
    pin_mode = '0; pt_en = '0; pt_use = '0; pt_pol = '0;
    m_data = '0; m_dir = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R2 R3: directed I/O patterns
    wr(1'b1, 8'hA5);
    wr(1'b0, 8'h3C);
    check_all("R3 io A5/3C");
    wr(1'b0, 8'hC3);
    check_all("R2 data rewrite");

    // R8: reserved code behaves as I/O
    pin_mode = {8{2'b11}};
    check_all("R8 reserved");

    // R5: latch then hold with strobe low
    pin_mode = {8{2'b01}};
    latch(8'h5A);
    addr_in = 8'hFF;
    tick();
    check_all("R5 latch hold");
    chk("R5 latched value", pin_out, 8'h5A);

    // R6 R7: single-literal chip selects
    pin_mode = {8{2'b10}};
    pt_en[0] = 1'b1; pt_use[0*NI+0] = 1'b1; pt_pol[0*NI+0] = 1'b1;   // pin0 term0: addr bit0 true
    pt_en[17] = 1'b1; pt_use[17*NI+8] = 1'b1; pt_pol[17*NI+8] = 1'b0; // pin4 term1: ctrl bit0 complemented
    ctrl_in = 4'h0;
    check_all("R6 cs literals a");
    chk("R6 cs pin0 low on addr bit0=0? no", {pin_out[4], pin_out[0]}, 2'b01);
    latch(8'h01); ctrl_in = 4'h1;
    check_all("R6 cs literals b");
    chk("R7 cs pin0 low pin4 high", {pin_out[7], pin_out[4], pin_out[0]}, 3'b110);

    // R9: register writes during another mode survive the mode change
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'hF0);
    pin_mode = '0;
    check_all("R9 back to io");

    // random sweep
    for (int it = 0; it < 400; it++) begin
      if (it % 20 == 0) begin
        for (int k = 0; k < TOT; k++) pt_en[k] = ($urandom % 4) != 0;
        for (int i = 0; i < TOT * NI; i++) begin
          pt_use[i] = ($urandom % 5) == 0;
          pt_pol[i] = $urandom % 2;
        end
      end
      pin_mode = 16'($urandom);
      ctrl_in = 4'($urandom);
      ext = 8'($urandom);
      host_we = ($urandom % 3) == 0;
      host_sel = $urandom % 2;
      host_wdata = 8'($urandom);
      addr_strobe = ($urandom % 2) == 0;
      addr_in = 8'($urandom);
      tick();
      check_all("R6 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule